// File: doc/BRIEF.md
# Tag Memory with Equality Compare

This block is a tag store for a cache controller. A 12-bit address picks one of 4096 entries; each entry holds a data word (4 bits by default) and a valid flag. Three active-low controls select the operation of each clock cycle: store the input word, drive the stored word out, compare the input word with the stored word, or invalidate the whole array at once.

All state changes on the rising clock edge. The read path is combinational from the address, so keeping output-enable low while the address changes streams entries out with no other control activity. The tri-state output is modelled as a data bus with a separate valid flag. The compare result is registered and appears one cycle after the compare is sampled.

Top module: `tag_compare_ram`

## Requirements
- R1: With clr_ni high and we_ni low, the edge stores data_i at addr_i and marks that entry valid, whatever the level of oe_ni.
- R2: With clr_ni and we_ni high and oe_ni low, data_vld_o is 1 and data_o shows the word stored at addr_i in the same cycle, following address changes with no clock edge.
- R3: When oe_ni is high, we_ni is low or clr_ni is low, data_vld_o is 0 and data_o is all zeros.
- R4: With clr_ni, we_ni and oe_ni all high, match_o becomes 1 after the edge only if the addressed entry is valid and its word equals data_i, and becomes 0 otherwise.
- R5: match_o is 0 in the cycle after any edge sampling a write, a read or a clear.
- R6: An edge with clr_ni low invalidates every entry, so later compares miss until each entry is written again.
- R7: A clear takes priority over a write in the same cycle: the write is dropped and the stored word is unchanged.
- R8: After reset every entry is invalid and match_o is 0.
- R9: Entries 0 and 4095 are independent: a write to one does not change the word or valid flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Entry address |
| data_i | input | DATA_W | Word to store or compare |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| clr_ni | input | 1 | Flash clear, active low |
| data_o | output | DATA_W | Read word, zero when disabled |
| data_vld_o | output | 1 | High when data_o is driven |
| match_o | output | 1 | Registered compare hit |

## Verification
The two functions that can fall in the same cycle are the flash clear and a write, because clr_ni and we_ni are independent pins. The bench drives both low on one edge to an entry that already holds a known word. It then reads the entry to confirm the old word survived and compares it to confirm the entry is invalid. A compare issued right after a clear, and a write followed at once by a compare of the same entry, cover the sequences next to that collision.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  typedef enum logic [1:0] {
    OP_CMP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_CLR = 2'd3
  } tcr_op_e;
endpackage

// File: rtl/tcr_decode.sv
module tcr_decode
  import tcr_pkg::*;
(
  input  logic    we_ni,
  input  logic    oe_ni,
  input  logic    clr_ni,
  output tcr_op_e op_o
);
  // clear > write > read > compare
  always_comb begin
    if (!clr_ni)     op_o = OP_CLR;
    else if (!we_ni) op_o = OP_WR;
    else if (!oe_ni) op_o = OP_RD;
    else             op_o = OP_CMP;
  end
endmodule

// File: rtl/tcr_valid.sv
module tcr_valid #(
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vld_o
);
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vld_q <= '0;
    else if (clr_i)  vld_q <= '0;
    else if (wr_i)   vld_q[addr_i] <= 1'b1;
  end

  assign vld_o = vld_q[addr_i];

  // R6
  flash_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_q == '0));
  // R1
  wr_sets_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> vld_q[$past(addr_i)]);
endmodule

// File: rtl/tcr_array.sv
module tcr_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/tag_compare_ram.sv
module tag_compare_ram
  import tcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              clr_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              data_vld_o,
  output logic              match_o
);
  tcr_op_e           op;
  logic              entry_vld;
  logic [DATA_W-1:0] rdata;
  logic              wr_en, clr_en, rd_en, cmp_en;
  logic              match_q;

  tcr_decode u_decode (
    .we_ni (we_ni),
    .oe_ni (oe_ni),
    .clr_ni(clr_ni),
    .op_o  (op)
  );

  assign wr_en  = (op == OP_WR);
  assign clr_en = (op == OP_CLR);
  assign rd_en  = (op == OP_RD);
  assign cmp_en = (op == OP_CMP);

  tcr_valid #(.ADDR_W(ADDR_W)) u_valid (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_en),
    .wr_i  (wr_en),
    .addr_i(addr_i),
    .vld_o (entry_vld)
  );

  tcr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i  (clk_i),
    .wr_i   (wr_en),
    .addr_i (addr_i),
    .wdata_i(data_i),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= cmp_en && entry_vld && (rdata == data_i);
  end

  assign match_o    = match_q;
  assign data_vld_o = rd_en;
  assign data_o     = rd_en ? rdata : '0;

  // R5
  no_match_outside_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en |=> !match_o);
  // R4
  no_match_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en && !entry_vld) |=> !match_o);
  // R3
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_vld_o |-> (data_o == '0));
endmodule

// File: tb/tag_compare_ram_tb.sv
`timescale 1ns/1ps
module tag_compare_ram_tb;
  localparam int AW = 12;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
  logic [DW-1:0] dout;
  logic          dvld, match;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tag_compare_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .we_ni(we_n), .oe_ni(oe_n), .clr_ni(clr_n),
    .data_o(dout), .data_vld_o(dvld), .match_o(match)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on negedge, return 1ns after the sampling edge
  task automatic op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic w, input logic o, input logic c);
    @(negedge clk);
    addr = a; din = d; we_n = w; oe_n = o; clr_n = c;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    op(a, d, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic cmp(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit exp, input string req);
    op(a, d, 1'b1, 1'b1, 1'b1);
    check(match == exp, req, match, exp);
  endtask

  task automatic rd_now(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    addr = a; we_n = 1'b1; oe_n = 1'b0; clr_n = 1'b1;
    #1;
    check(dvld == 1'b1, req, dvld, 1);
    check(dout == exp, req, dout, exp);
  endtask

  task automatic t_reset;
    check(match == 1'b0, "R8", match, 0);
    cmp(12'd5, 4'd0, 1'b0, "R8");
    cmp(12'd4095, 4'd0, 1'b0, "R8");
  endtask

  task automatic t_write_compare;
    wr(12'd10, 4'hA);
    check(match == 1'b0, "R5", match, 0);
    cmp(12'd10, 4'hA, 1'b1, "R4");
    cmp(12'd10, 4'h5, 1'b0, "R4");
    // oe low during write is ignored (R1)
    op(12'd11, 4'h3, 1'b0, 1'b0, 1'b1);
    check(dvld == 1'b0, "R3", dvld, 0);
    check(dout == '0, "R3", dout, 0);
    cmp(12'd11, 4'h3, 1'b1, "R1");
    cmp(12'd12, 4'h0, 1'b0, "R4");
  endtask

  task automatic t_read_stream;
    wr(12'd20, 4'h1);
    wr(12'd21, 4'hE);
    wr(12'd22, 4'h7);
    // R2 continuous read: address moves within one low clock phase
    @(negedge clk);
    we_n = 1'b1; oe_n = 1'b0; clr_n = 1'b1; addr = 12'd20;
    #1; check(dvld == 1'b1 && dout == 4'h1, "R2", dout, 4'h1);
    addr = 12'd21;
    #1; check(dout == 4'hE, "R2", dout, 4'hE);
    addr = 12'd22;
    #1; check(dout == 4'h7, "R2", dout, 4'h7);
    @(posedge clk); #1;
    check(match == 1'b0, "R5", match, 0);
    @(negedge clk);
    oe_n = 1'b1;
    #1; check(dvld == 1'b0 && dout == '0, "R3", dout, 0);
  endtask

  task automatic t_flash_clear;
    wr(12'd30, 4'h9);
    cmp(12'd30, 4'h9, 1'b1, "R4");
    op(12'd0, 4'h0, 1'b1, 1'b0, 1'b0);
    check(dvld == 1'b0, "R3", dvld, 0);
    check(match == 1'b0, "R5", match, 0);
    cmp(12'd30, 4'h9, 1'b0, "R6");
    cmp(12'd10, 4'hA, 1'b0, "R6");
    wr(12'd30, 4'h9);
    cmp(12'd30, 4'h9, 1'b1, "R6");
  endtask

  task automatic t_clear_vs_write;
    wr(12'd40, 4'h6);
    op(12'd40, 4'hB, 1'b0, 1'b1, 1'b0);
    rd_now(12'd40, 4'h6, "R7");
    cmp(12'd40, 4'h6, 1'b0, "R7");
    cmp(12'd40, 4'hB, 1'b0, "R7");
  endtask

  task automatic t_edges;
    wr(12'd0, 4'h2);
    wr(12'd4095, 4'hD);
    rd_now(12'd0, 4'h2, "R9");
    rd_now(12'd4095, 4'hD, "R9");
    cmp(12'd0, 4'h2, 1'b1, "R9");
    cmp(12'd4095, 4'hD, 1'b1, "R9");
    wr(12'd4095, 4'h0);
    cmp(12'd0, 4'h2, 1'b1, "R9");
    cmp(12'd4095, 4'h0, 1'b1, "R9");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write_compare();
        t_read_stream();
        t_flash_clear();
        t_clear_vs_write();
        t_edges();
      end
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule